// File: doc/BRIEF.md
# Station Address PROM Shadow Loader

This block keeps a 16-byte shadow copy of the start of an external serial EEPROM. When reset is released, it reads the image on its own. It uses a three-wire serial read sequence on a divided clock and fills the shadow two bytes per EEPROM word. No host action is needed. When the load ends, it checks the image layout. Bytes 0 to 5 hold a 48-bit station address and bytes 6 to 11 are reserved. Bytes 12 and 13 hold a 16-bit checksum, and bytes 14 and 15 are fixed signature bytes.

The host reads any shadow byte through a byte-addressed port. The host may overwrite a byte only while a separate write-enable input is high. The shadow is plain storage. Its content steers nothing in the block except the one-time validity verdict taken at the end of the load.

Top module: `prom_shadow_loader`

## Requirements
- R1: Loading starts by itself after reset and reads EEPROM words 0 to 7 in ascending order. Each read is one chip-select window. The window carries a start bit 1, then opcode bits 1 then 0, then a 6-bit word address MSB first. After that the EEPROM returns 16 data bits MSB first. The EEPROM samples `ee_di` on rising `ee_sk`. The block samples `ee_do` just before each falling `ee_sk` of serial bits 9 to 24.
- R2: The first eight data bits of word w (its high half) go to byte 2w+1. The last eight bits (its low half) go to byte 2w.
- R3: `load_done` is 0 from reset until the load ends, then rises and stays 1. After that, chip select and the serial clock stay low.
- R4: `image_valid` is 1 only when both checks hold. The checksum must match, and bytes 14 and 15 must each equal 0x57. Otherwise it is 0, including while loading.
- R5: The checksum is the 16-bit modulo sum of bytes 1 to 11, 14 and 15. Byte 12 must hold its low half and byte 13 its high half.
- R6: While `load_done` is 0, `host_rdata` reads 0x00 for every address.
- R7: After loading, `host_rdata` shows the addressed byte at once. A `host_we` pulse with `host_wr_en` high replaces that byte on the next clock edge.
- R8: A `host_we` pulse is ignored when `host_wr_en` is low. It is also ignored while loading is in progress.
- R9: Host writes never change `image_valid`. The verdict is taken once, at the end of the load.
- R10: `ee_sk` pulses only while `ee_cs` is high. `ee_di` does not change while `ee_sk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset; starts a new load when released |
| ee_cs | output | 1 | EEPROM chip select, high during a word read |
| ee_sk | output | 1 | EEPROM serial clock, CLK_DIV system cycles per half period |
| ee_di | output | 1 | Serial command bits to the EEPROM |
| ee_do | input | 1 | Serial data bits from the EEPROM |
| host_addr | input | 4 | Shadow byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_wr_en | input | 1 | Write-enable bit; host writes take effect only while high |
| host_rdata | output | 8 | Addressed shadow byte, or 0x00 while loading |
| load_done | output | 1 | Load finished |
| image_valid | output | 1 | Loaded image passed the checksum and signature checks |

## Verification
The assertions assume reset is held until the first clock edges have passed. They also assume `ee_do` changes only while `ee_sk` is low, as a real EEPROM output does. The bench meets the second condition with an EEPROM model that updates its output only on the falling serial clock. The first condition is met by holding reset for several cycles before each load. The bench drives host strobes and addresses on the falling system clock edge, so the design sees them settled at the rising edge.

// File: rtl/prom_shadow_loader.sv
module prom_shadow_loader #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do,
  input  logic [3:0] host_addr,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  input  logic       host_wr_en,
  output logic [7:0] host_rdata,
  output logic       load_done,
  output logic       image_valid
);

  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [7:0] SIG = 8'h57;

  logic [7:0]    mem [16];
  logic [DW-1:0] div_cnt;
  logic          busy, ph, fin;
  logic [4:0]    bcnt;
  logic [2:0]    wrd;
  logic [8:0]    cmd_sr;
  logic [15:0]   shreg, sum;
  logic          tick, img_ok;
  logic [15:0]   nxt;

  assign tick  = busy && (div_cnt == DW'(CLK_DIV - 1));
  assign nxt   = {shreg[14:0], ee_do};
  assign ee_sk = ph && ee_cs;
  assign ee_di = ee_cs && cmd_sr[8];
  assign host_rdata = load_done ? mem[host_addr] : 8'h00;

  always_comb begin
    sum = 16'h0000;
    for (int i = 1; i < 16; i++)
      if (i != 12 && i != 13) sum = sum + {8'h00, mem[i]};
  end

  assign img_ok = (sum == {mem[13], mem[12]}) && (mem[14] == SIG) && (mem[15] == SIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b1;
      div_cnt     <= '0;
      ph          <= 1'b0;
      ee_cs       <= 1'b0;
      bcnt        <= '0;
      wrd         <= '0;
      cmd_sr      <= '0;
      shreg       <= '0;
      fin         <= 1'b0;
      load_done   <= 1'b0;
      image_valid <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
    end else begin
      fin <= 1'b0;
      if (busy) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (!ee_cs) begin
          ee_cs  <= 1'b1;
          bcnt   <= '0;
          cmd_sr <= {3'b110, 3'b000, wrd};
        end else if (!ph) begin
          ph <= 1'b1;
        end else begin
          ph     <= 1'b0;
          cmd_sr <= {cmd_sr[7:0], 1'b0};
          if (bcnt >= 5'd9) shreg <= nxt;
          if (bcnt == 5'd24) begin
            mem[{wrd, 1'b0}] <= nxt[7:0];
            mem[{wrd, 1'b1}] <= nxt[15:8];
            ee_cs <= 1'b0;
            wrd   <= wrd + 1'b1;
            if (wrd == 3'd7) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end
      if (fin) begin
        load_done   <= 1'b1;
        image_valid <= img_ok;
      end
      if (load_done && host_we && host_wr_en) mem[host_addr] <= host_wdata;
    end
  end

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  p_bus_idle_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!ee_cs && !ee_sk));
  p_valid_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    image_valid |-> load_done);
  p_valid_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && $past(load_done)) |-> $stable(image_valid));
  p_di_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

endmodule

// File: tb/prom_shadow_loader_tb.sv
`timescale 1ns/1ps
module prom_shadow_loader_tb;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0;
  logic ee_cs, ee_sk, ee_di, ee_do = 0;
  logic [3:0] host_addr = 0;
  logic host_we = 0, host_wr_en = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic load_done, image_valid;

  int checks = 0, errors = 0;
  logic [7:0] img [16];
  int n = 0, exp_word = 0, cmd_errs = 0;
  logic [8:0] cmd = 0;
  logic [5:0] rd_addr = 0;

  always #10 clk = ~clk;

  prom_shadow_loader #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_wr_en(host_wr_en),
    .host_rdata(host_rdata), .load_done(load_done), .image_valid(image_valid));

  always @(posedge ee_sk or posedge ee_cs) begin
    if (!ee_sk) n = 0;
    else if (n < 9) begin
      cmd = {cmd[7:0], ee_di};
      n = n + 1;
      if (n == 9) begin
        if (cmd[8:6] != 3'b110 || cmd[5:0] != 6'(exp_word)) cmd_errs = cmd_errs + 1;
        rd_addr = cmd[5:0];
        exp_word = exp_word + 1;
      end
    end else n = n + 1;
  end

  always @(negedge ee_sk) begin
    if (n >= 9 && n < 25) ee_do = word_of(rd_addr)[15 - (n - 9)];
  end

  function automatic logic [15:0] word_of(logic [5:0] a);
    return (a < 8) ? {img[2*a+1], img[2*a]} : 16'h0000;
  endfunction

  function automatic logic [15:0] csum();
    logic [15:0] s = 0;
    for (int i = 1; i < 16; i++) if (i != 12 && i != 13) s = s + {8'h00, img[i]};
    return s;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic base_image();
    logic [7:0] sa [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int i = 0; i < 6; i++) img[i] = sa[i];
    for (int i = 6; i < 12; i++) img[i] = 8'hA0 + 8'(i);
    img[14] = 8'h57; img[15] = 8'h57;
    {img[13], img[12]} = csum();
  endtask

  task automatic do_reset();
    rst_n = 0; exp_word = 0; cmd_errs = 0;
    repeat (4) @(negedge clk);
    chk("R3", {15'h0, load_done}, 16'h0, "done during reset");
    chk("R4", {15'h0, image_valid}, 16'h0, "valid during reset");
    chk("R3", {15'h0, ee_cs}, 16'h0, "cs during reset");
    rst_n = 1;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!load_done && k < 5000) begin @(negedge clk); k++; end
    chk("R3", {15'h0, load_done}, 16'h1, "load finished");
    chk("R1", 16'(cmd_errs), 16'h0, "command/address errors");
    chk("R1", 16'(exp_word), 16'd8, "words read");
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, logic en);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr_en = en; host_we = 1;
    @(negedge clk); host_we = 0; host_wr_en = 0;
  endtask

  task automatic t_valid_load();
    logic [7:0] d;
    base_image();
    do_reset();
    wait_done();
    chk("R4", {15'h0, image_valid}, 16'h1, "valid image");
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), d);
      chk("R2", {8'h0, d}, {8'h0, img[i]}, $sformatf("byte %0d", i));
    end
    repeat (20) @(negedge clk);
    chk("R3", {14'h0, ee_cs, ee_sk}, 16'h0, "serial idle after load");
  endtask

  task automatic t_during_load();
    logic [7:0] d;
    base_image();
    do_reset();
    repeat (30) @(negedge clk);
    rd(4'd0, d);  chk("R6", {8'h0, d}, 16'h0, "read byte 0 while loading");
    rd(4'd14, d); chk("R6", {8'h0, d}, 16'h0, "read byte 14 while loading");
    wr(4'd2, 8'hC3, 1'b1);
    wait_done();
    rd(4'd2, d);  chk("R8", {8'h0, d}, {8'h0, img[2]}, "write during load ignored");
  endtask

  task automatic t_bad_checksum();
    base_image();
    img[12] = img[12] + 8'h01;
    do_reset(); wait_done();
    chk("R5", {15'h0, image_valid}, 16'h0, "checksum off by one");
    base_image();
    {img[12], img[13]} = {img[13], img[12]};
    if (img[12] == img[13]) img[13] = img[13] + 1;
    do_reset(); wait_done();
    chk("R5", {15'h0, image_valid}, 16'h0, "checksum halves swapped");
  endtask

  task automatic t_bad_signature();
    base_image();
    img[15] = 8'h58;
    {img[13], img[12]} = csum();
    do_reset(); wait_done();
    chk("R4", {15'h0, image_valid}, 16'h0, "signature byte 15 wrong");
    base_image();
    img[14] = 8'h56;
    {img[13], img[12]} = csum();
    do_reset(); wait_done();
    chk("R4", {15'h0, image_valid}, 16'h0, "signature byte 14 wrong");
  endtask

  task automatic t_host_writes();
    logic [7:0] d;
    base_image();
    do_reset(); wait_done();
    wr(4'd3, 8'hEE, 1'b0);
    rd(4'd3, d); chk("R8", {8'h0, d}, {8'h0, img[3]}, "write with enable low");
    wr(4'd3, 8'hEE, 1'b1);
    rd(4'd3, d); chk("R7", {8'h0, d}, 16'h00EE, "write with enable high");
    wr(4'd14, 8'h00, 1'b1);
    rd(4'd14, d); chk("R7", {8'h0, d}, 16'h0000, "overwrite signature");
    repeat (3) @(negedge clk);
    chk("R9", {15'h0, image_valid}, 16'h1, "valid unchanged by writes");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_valid_load();
    t_during_load();
    t_bad_checksum();
    t_bad_signature();
    t_host_writes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule